// File: doc/BRIEF.md
# Cascaded Lookup Result Arbiter

This block sits on the response side of one ternary search device in a depth-cascaded group of up to eight devices that all search the same key at once. The per-segment priority encoders hand it a hit flag, an in-segment multiple-hit flag and a local location for every segment. It picks the winning segment and tells lower-priority devices through a match-out line that it has hit. It hears about upstream hits on a match-in line. From these it decides whether this device owns the result.

The arbiter builds the index word and drives the response strobes: lookup valid, match acknowledge, a multi-match pull, and the chip-enable and write-enable for the external result memory. Two strap inputs set its role. The final-device strap makes the device drive the feedback signals to the host. The memory-owner strap makes it drive chip-enable and write-enable. The memory-owner device also places the index of SRAM writes and learns on the bus, and it drives the index bus by default so that the bus never floats. Every bus has an explicit output-enable rather than a real tristate. Reset clears every output and every enable.

A request is sampled on clock edge k. Match-out is valid after edge k, and match-in is read in that same cycle. All other responses appear for one cycle after edge k+1.

Top module: `casc_result_arb`

## Requirements
- R1: While reset is asserted, every output is low: all enables, all strobes, match-out and the index.
- R2: Match-out is high in the cycle after a lookup (op code 0) is sampled with at least one segment hit. It is low after a miss, a write, a learn or an idle cycle.
- R3: A device that hits while match-in is low asserts idx_oe_o for the one response cycle. In that cycle it drives the index {lookup type, device address, segment number, local location}, with the type in the top bits and the location in the bottom LOCW bits.
- R4: When match-in is high during a hitting lookup, the device does not drive the index bus in the response cycle.
- R5: When several segments hit, the lowest-numbered segment wins and its local location is reported.
- R6: The multi-match pull is high in the response cycle of a lookup in any of these cases: two or more segments hit; a hitting segment flags several hits; or this device hits while match-in is high.
- R7: Only a final-device-strapped device drives feedback. For every lookup it raises fb_oe_o and lookup_valid_o for one cycle. It raises match_ack_o exactly when this device or an upstream device hit. Other devices hold all three low.
- R8: Only a memory-owner-strapped device raises sram_oe_o, ce_o and we_o. It raises ce_o for a lookup hit anywhere in the cascade and for writes. For learn (op 1) and SRAM write (op 2) it raises we_o together with ce_o and drives wr_index_i on the index bus.
- R9: Outside its own response cycles, a memory-owner device drives the index bus with zero. This covers idle cycles and lookups where no device hit.
- R10: Op code 3 is ignored. It raises no match-out and no response, and it does not change the bus state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| dev_addr_i | input | 3 | Strapped device position in the cascade |
| last_dev_i | input | 1 | Strap: this device drives host feedback |
| last_sram_i | input | 1 | Strap: this device drives memory controls and the default index |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 2 | 0 lookup, 1 learn, 2 SRAM write, 3 ignored |
| req_type_i | input | TW | Lookup type carried into the index |
| seg_hit_i | input | NSEG | Per-segment hit flags |
| seg_multi_i | input | NSEG | Per-segment several-hits flags |
| seg_loc_i | input | NSEG*LOCW | Per-segment local locations, segment 0 lowest |
| wr_index_i | input | IW | Index for learn and SRAM write |
| match_in_i | input | 1 | OR of all upstream match-out lines |
| match_out_o | output | 1 | This device hit on the staged lookup |
| idx_o | output | IW | Index word |
| idx_oe_o | output | 1 | Index bus enable |
| ce_o | output | 1 | Memory chip-enable |
| we_o | output | 1 | Memory write-enable |
| sram_oe_o | output | 1 | Enable for ce_o and we_o |
| lookup_valid_o | output | 1 | Lookup completed |
| match_ack_o | output | 1 | Lookup hit somewhere in the cascade |
| fb_oe_o | output | 1 | Enable for the feedback lines |
| multi_match_o | output | 1 | Open-drain multi-match pull |

## Verification
The assertions assume that the straps change only between operations, so a strap value read on one edge still describes the response produced on the next. They assume that match-in carries only upstream hits for the lookup staged in the same cycle. They also assume that a memory-owner device sits lowest in the priority order, so its match-in reflects every hit above it. The stimulus keeps to these assumptions: match-in is driven only in the cycle after a lookup is sampled, and it is zero otherwise. Straps are changed together with request issue, and the role combinations are exercised group by group.

// File: rtl/casc_arb_pkg.sv
package casc_arb_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP  = 2'd0,
    OP_LEARN   = 2'd1,
    OP_SRAM_WR = 2'd2,
    OP_RSVD    = 2'd3
  } arb_op_e;

  localparam int DEV_AW = 3;
endpackage

// File: rtl/casc_arb_seg_pick.sv
module casc_arb_seg_pick #(
  parameter int NSEG = 4,
  parameter int LOCW = 12,
  localparam int SEGW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic [NSEG-1:0]      hit_i,
  input  logic [NSEG-1:0]      multi_i,
  input  logic [NSEG*LOCW-1:0] loc_i,
  output logic                 any_o,
  output logic                 multi_o,
  output logic [NSEG-1:0]      sel_o,
  output logic [SEGW-1:0]      seg_o,
  output logic [LOCW-1:0]      loc_o
);
  // isolate lowest set bit: lowest segment number has priority
  function automatic logic [NSEG-1:0] lowest_bit(input logic [NSEG-1:0] v);
    return v & (~v + NSEG'(1));
  endfunction

  function automatic logic [SEGW-1:0] onehot_bin(input logic [NSEG-1:0] oh);
    logic [SEGW-1:0] b;
    b = '0;
    for (int i = 0; i < NSEG; i++)
      if (oh[i]) b = b | SEGW'(i);
    return b;
  endfunction

  logic [LOCW-1:0] loc_arr [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_unpack
    assign loc_arr[g] = loc_i[g*LOCW +: LOCW];
  end

  assign sel_o   = lowest_bit(hit_i);
  assign any_o   = |hit_i;
  assign seg_o   = onehot_bin(sel_o);
  assign multi_o = ($countones(hit_i) > 1) || (|(hit_i & multi_i));

  always_comb begin
    loc_o = '0;
    for (int i = 0; i < NSEG; i++)
      if (sel_o[i]) loc_o = loc_o | loc_arr[i];
  end
endmodule

// File: rtl/casc_arb_stage.sv
module casc_arb_stage
  import casc_arb_pkg::*;
#(
  parameter int NSEG = 4,
  parameter int LOCW = 12,
  parameter int TW   = 2,
  parameter int IW   = 19,
  localparam int SEGW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [1:0]           req_op_i,
  input  logic [TW-1:0]        req_type_i,
  input  logic [NSEG-1:0]      seg_hit_i,
  input  logic [NSEG-1:0]      seg_multi_i,
  input  logic [NSEG*LOCW-1:0] seg_loc_i,
  input  logic [IW-1:0]        wr_index_i,
  input  logic                 match_in_i,
  output logic                 match_out_o,
  output logic                 resp_lk_o,
  output logic                 resp_wr_o,
  output logic                 win_o,
  output logic                 any_hit_o,
  output logic                 multi_o,
  output logic [TW-1:0]        type_o,
  output logic [SEGW-1:0]      seg_o,
  output logic [LOCW-1:0]      loc_o,
  output logic [IW-1:0]        wr_index_o
);
  logic                 st_valid;
  logic [1:0]           st_op;
  logic [TW-1:0]        st_type;
  logic [NSEG-1:0]      st_hit;
  logic [NSEG-1:0]      st_multi;
  logic [NSEG*LOCW-1:0] st_loc;
  logic [IW-1:0]        st_wr;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_valid <= 1'b0;
      st_op    <= OP_RSVD;
      st_type  <= '0;
      st_hit   <= '0;
      st_multi <= '0;
      st_loc   <= '0;
      st_wr    <= '0;
    end else begin
      st_valid <= req_valid_i;
      st_op    <= req_op_i;
      st_type  <= req_type_i;
      st_hit   <= seg_hit_i;
      st_multi <= seg_multi_i;
      st_loc   <= seg_loc_i;
      st_wr    <= wr_index_i;
    end
  end

  logic            pick_any;
  logic            pick_multi;
  logic [NSEG-1:0] pick_sel;
  logic            local_hit;

  casc_arb_seg_pick #(.NSEG(NSEG), .LOCW(LOCW)) u_pick (
    .hit_i   (st_hit),
    .multi_i (st_multi),
    .loc_i   (st_loc),
    .any_o   (pick_any),
    .multi_o (pick_multi),
    .sel_o   (pick_sel),
    .seg_o   (seg_o),
    .loc_o   (loc_o)
  );

  assign resp_lk_o   = st_valid && (st_op == OP_LOOKUP);
  assign resp_wr_o   = st_valid && ((st_op == OP_LEARN) || (st_op == OP_SRAM_WR));
  assign local_hit   = resp_lk_o && pick_any;
  assign match_out_o = local_hit;
  assign win_o       = local_hit && !match_in_i;
  assign any_hit_o   = local_hit || match_in_i;
  assign multi_o     = resp_lk_o && (pick_multi || (local_hit && match_in_i));
  assign type_o      = st_type;
  assign wr_index_o  = st_wr;

  // R2: a sampled hitting lookup raises match-out in the next cycle
  p_match_out_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(req_valid_i && (req_op_i == OP_LOOKUP) && (|seg_hit_i)))
      |-> match_out_o);
  // R5: the picked segment is a single one and it really hit
  p_pick_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pick_sel) && ((pick_sel & ~st_hit) == '0));
  // R6: cross-device overlap always yields a multi-match
  p_cascade_multi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_out_o && match_in_i) |-> multi_o);
endmodule

// File: rtl/casc_arb_drive.sv
module casc_arb_drive #(
  parameter int TW   = 2,
  parameter int DEVW = 3,
  parameter int SEGW = 2,
  parameter int LOCW = 12,
  localparam int IW  = TW + DEVW + SEGW + LOCW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DEVW-1:0] dev_addr_i,
  input  logic            last_dev_i,
  input  logic            last_sram_i,
  input  logic            resp_lk_i,
  input  logic            resp_wr_i,
  input  logic            win_i,
  input  logic            any_hit_i,
  input  logic            multi_i,
  input  logic [TW-1:0]   type_i,
  input  logic [SEGW-1:0] seg_i,
  input  logic [LOCW-1:0] loc_i,
  input  logic [IW-1:0]   wr_index_i,
  output logic [IW-1:0]   idx_o,
  output logic            idx_oe_o,
  output logic            ce_o,
  output logic            we_o,
  output logic            sram_oe_o,
  output logic            valid_o,
  output logic            ack_o,
  output logic            fb_oe_o,
  output logic            mm_o
);
  function automatic logic [IW-1:0] build_index(
    input logic [TW-1:0] t, input logic [DEVW-1:0] d,
    input logic [SEGW-1:0] s, input logic [LOCW-1:0] l);
    return {t, d, s, l};
  endfunction

  logic lk_hit_any;
  assign lk_hit_any = resp_lk_i && any_hit_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      idx_o     <= '0;
      idx_oe_o  <= 1'b0;
      ce_o      <= 1'b0;
      we_o      <= 1'b0;
      sram_oe_o <= 1'b0;
      valid_o   <= 1'b0;
      ack_o     <= 1'b0;
      fb_oe_o   <= 1'b0;
      mm_o      <= 1'b0;
    end else begin
      idx_oe_o  <= win_i || (last_sram_i && !lk_hit_any);
      idx_o     <= win_i ? build_index(type_i, dev_addr_i, seg_i, loc_i)
                         : (resp_wr_i ? wr_index_i : '0);
      sram_oe_o <= last_sram_i;
      ce_o      <= last_sram_i && (lk_hit_any || resp_wr_i);
      we_o      <= last_sram_i && resp_wr_i;
      fb_oe_o   <= last_dev_i && resp_lk_i;
      valid_o   <= last_dev_i && resp_lk_i;
      ack_o     <= last_dev_i && lk_hit_any;
      mm_o      <= multi_i;
    end
  end

  // R3: a won lookup drives the index bus in the following cycle
  p_owner_drives_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(win_i)) |-> idx_oe_o);
  // R4: a device that neither won nor owns the memory leaves the bus alone
  p_quiet_loser_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(!win_i && !last_sram_i)) |-> !idx_oe_o);
  // R7: acknowledge only inside a driven valid strobe
  p_ack_in_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (valid_o && fb_oe_o));
  // R8: write-enable never without chip-enable
  p_we_with_ce_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> ce_o);
  // R8: a non-owner strap keeps the memory controls off
  p_nonsram_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_sram_i |=> (!ce_o && !we_o && !sram_oe_o));
endmodule

// File: rtl/casc_result_arb.sv
module casc_result_arb #(
  parameter int NSEG = 4,
  parameter int LOCW = 12,
  parameter int TW   = 2,
  localparam int DEVW = casc_arb_pkg::DEV_AW,
  localparam int SEGW = (NSEG > 1) ? $clog2(NSEG) : 1,
  localparam int IW   = TW + DEVW + SEGW + LOCW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DEVW-1:0]      dev_addr_i,
  input  logic                 last_dev_i,
  input  logic                 last_sram_i,
  input  logic                 req_valid_i,
  input  logic [1:0]           req_op_i,
  input  logic [TW-1:0]        req_type_i,
  input  logic [NSEG-1:0]      seg_hit_i,
  input  logic [NSEG-1:0]      seg_multi_i,
  input  logic [NSEG*LOCW-1:0] seg_loc_i,
  input  logic [IW-1:0]        wr_index_i,
  input  logic                 match_in_i,
  output logic                 match_out_o,
  output logic [IW-1:0]        idx_o,
  output logic                 idx_oe_o,
  output logic                 ce_o,
  output logic                 we_o,
  output logic                 sram_oe_o,
  output logic                 lookup_valid_o,
  output logic                 match_ack_o,
  output logic                 fb_oe_o,
  output logic                 multi_match_o
);
  logic            resp_lk, resp_wr, win, any_hit, multi;
  logic [TW-1:0]   st_type;
  logic [SEGW-1:0] st_seg;
  logic [LOCW-1:0] st_loc;
  logic [IW-1:0]   st_wr;

  casc_arb_stage #(.NSEG(NSEG), .LOCW(LOCW), .TW(TW), .IW(IW)) u_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_op_i    (req_op_i),
    .req_type_i  (req_type_i),
    .seg_hit_i   (seg_hit_i),
    .seg_multi_i (seg_multi_i),
    .seg_loc_i   (seg_loc_i),
    .wr_index_i  (wr_index_i),
    .match_in_i  (match_in_i),
    .match_out_o (match_out_o),
    .resp_lk_o   (resp_lk),
    .resp_wr_o   (resp_wr),
    .win_o       (win),
    .any_hit_o   (any_hit),
    .multi_o     (multi),
    .type_o      (st_type),
    .seg_o       (st_seg),
    .loc_o       (st_loc),
    .wr_index_o  (st_wr)
  );

  casc_arb_drive #(.TW(TW), .DEVW(DEVW), .SEGW(SEGW), .LOCW(LOCW)) u_drive (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dev_addr_i  (dev_addr_i),
    .last_dev_i  (last_dev_i),
    .last_sram_i (last_sram_i),
    .resp_lk_i   (resp_lk),
    .resp_wr_i   (resp_wr),
    .win_i       (win),
    .any_hit_i   (any_hit),
    .multi_i     (multi),
    .type_i      (st_type),
    .seg_i       (st_seg),
    .loc_i       (st_loc),
    .wr_index_i  (st_wr),
    .idx_o       (idx_o),
    .idx_oe_o    (idx_oe_o),
    .ce_o        (ce_o),
    .we_o        (we_o),
    .sram_oe_o   (sram_oe_o),
    .valid_o     (lookup_valid_o),
    .ack_o       (match_ack_o),
    .fb_oe_o     (fb_oe_o),
    .mm_o        (multi_match_o)
  );
endmodule

// File: tb/casc_result_arb_bench.sv
module casc_result_arb_bench;
  localparam int NSEG = 4;
  localparam int LOCW = 12;
  localparam int TW   = 2;
  localparam int SEGW = 2;
  localparam int IW   = TW + 3 + SEGW + LOCW;

  typedef struct {
    bit                 valid;
    bit [1:0]           op;
    bit [TW-1:0]        typ;
    bit [NSEG-1:0]      hit;
    bit [NSEG-1:0]      multi;
    bit [NSEG*LOCW-1:0] loc;
    bit [IW-1:0]        wr;
    bit                 min;
    string              tag;
  } item_t;

  typedef struct {
    bit          oe;
    bit [IW-1:0] idx;
    bit ce, we, soe, fb, val, ack, mm;
    string       tag;
  } resp_t;

  typedef struct {
    bit    mo;
    string tag;
  } mo_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] dev_addr = 3'd0;
  logic last_dev = 1'b0, last_sram = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [TW-1:0] req_type = '0;
  logic [NSEG-1:0] seg_hit = '0, seg_multi = '0;
  logic [NSEG*LOCW-1:0] seg_loc = '0;
  logic [IW-1:0] wr_index = '0;
  logic match_in = 1'b0;
  logic match_out, idx_oe, ce, we, sram_oe, lk_valid, m_ack, fb_oe, mm;
  logic [IW-1:0] idx;

  always #4 clk = ~clk;  // 125 MHz

  casc_result_arb u_casc_result_arb (
    .clk_i(clk), .rst_ni(rst_n), .dev_addr_i(dev_addr), .last_dev_i(last_dev),
    .last_sram_i(last_sram), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_type_i(req_type), .seg_hit_i(seg_hit), .seg_multi_i(seg_multi),
    .seg_loc_i(seg_loc), .wr_index_i(wr_index), .match_in_i(match_in),
    .match_out_o(match_out), .idx_o(idx), .idx_oe_o(idx_oe), .ce_o(ce),
    .we_o(we), .sram_oe_o(sram_oe), .lookup_valid_o(lk_valid),
    .match_ack_o(m_ack), .fb_oe_o(fb_oe), .multi_match_o(mm)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  resp_t q_out[$];
  mo_t   q_mo[$];
  item_t pend;
  bit [2:0] s_addr = 3'd0;
  bit s_dev = 1'b0, s_sram = 1'b0;

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic item_t mk(bit valid, bit [1:0] op, bit [TW-1:0] typ,
                               bit [NSEG-1:0] hit, bit [NSEG-1:0] multi,
                               bit [NSEG*LOCW-1:0] loc, bit [IW-1:0] wr,
                               bit min, string tag);
    item_t it;
    it.valid = valid; it.op = op; it.typ = typ; it.hit = hit; it.multi = multi;
    it.loc = loc; it.wr = wr; it.min = min; it.tag = tag;
    return it;
  endfunction

  // reference model, written from the requirements
  function automatic resp_t model(item_t p);
    resp_t r;
    bit lk, wr, lh, any, win, many;
    int seg, cnt;
    lk  = p.valid && (p.op == 2'd0);
    wr  = p.valid && (p.op == 2'd1 || p.op == 2'd2);
    lh  = lk && (p.hit != 0);
    any = lk && (lh || p.min);
    win = lh && !p.min;
    seg = 0; cnt = 0;
    for (int s = NSEG - 1; s >= 0; s--) if (p.hit[s]) begin seg = s; cnt++; end
    many = (cnt > 1) || ((p.hit & p.multi) != 0);
    r.oe  = win || (s_sram && !any);
    if (win)
      r.idx = {p.typ, s_addr, SEGW'(seg), p.loc[seg*LOCW +: LOCW]};
    else if (wr)
      r.idx = p.wr;
    else
      r.idx = '0;
    r.ce  = s_sram && (any || wr);
    r.we  = s_sram && wr;
    r.soe = s_sram;
    r.fb  = s_dev && lk;
    r.val = s_dev && lk;
    r.ack = s_dev && any;
    r.mm  = lk && (many || (lh && p.min));
    r.tag = p.tag;
    return r;
  endfunction

  // driver: new request, plus match-in for the one staged last cycle
  task automatic issue(item_t it);
    mo_t m;
    @(negedge clk);
    dev_addr  = s_addr; last_dev = s_dev; last_sram = s_sram;
    req_valid = it.valid; req_op = it.op; req_type = it.typ;
    seg_hit   = it.hit; seg_multi = it.multi; seg_loc = it.loc; wr_index = it.wr;
    match_in  = pend.min;
    q_out.push_back(model(pend));
    m.mo = it.valid && (it.op == 2'd0) && (it.hit != 0);
    m.tag = it.tag;
    q_mo.push_back(m);
    pend = it;
  endtask

  task automatic idle();
    issue(mk(0, 2'd0, '0, '0, '0, '0, '0, 0, "idle"));
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_mo.size() > 0) begin
        mo_t m;
        m = q_mo.pop_front();
        check({"R2 ", m.tag}, "match_out", 32'(match_out), 32'(m.mo));
      end
      if (q_out.size() > 0) begin
        resp_t e;
        e = q_out.pop_front();
        check({"R3/R4/R9 ", e.tag}, "idx_oe", 32'(idx_oe), 32'(e.oe));
        if (e.oe) check({"R3/R5 ", e.tag}, "idx", 32'(idx), 32'(e.idx));
        check({"R8 ", e.tag}, "ce", 32'(ce), 32'(e.ce));
        check({"R8 ", e.tag}, "we", 32'(we), 32'(e.we));
        check({"R8 ", e.tag}, "sram_oe", 32'(sram_oe), 32'(e.soe));
        check({"R7 ", e.tag}, "fb_oe", 32'(fb_oe), 32'(e.fb));
        check({"R7 ", e.tag}, "valid", 32'(lk_valid), 32'(e.val));
        check({"R7 ", e.tag}, "ack", 32'(m_ack), 32'(e.ack));
        check({"R6 ", e.tag}, "multi", 32'(mm), 32'(e.mm));
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam bit [NSEG*LOCW-1:0] LOCS = {12'hD04, 12'hC03, 12'h123, 12'hA01};

  initial begin
    pend = mk(0, 2'd0, '0, '0, '0, '0, '0, 0, "idle");
    s_addr = 3'd5; s_dev = 1; s_sram = 1;
    dev_addr = s_addr; last_dev = 1; last_sram = 1;
    seg_hit = 4'b1111; req_op = 2'd0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset quiets everything
    check("R1", "outputs", 32'({match_out, idx_oe, ce, we, sram_oe, lk_valid, m_ack, fb_oe, mm}), 32'd0);
    check("R1", "idx", 32'(idx), 32'd0);
    @(negedge clk);
    seg_hit = '0;
    rst_n = 1'b1;

    // group A: final device and memory owner
    idle();
    issue(mk(1, 2'd0, 2'd1, 4'b0100, '0, LOCS, '0, 0, "R3 single hit seg2"));
    issue(mk(1, 2'd0, 2'd2, 4'b1010, '0, LOCS, '0, 0, "R5 lowest of seg1,seg3"));
    issue(mk(1, 2'd0, 2'd3, 4'b0001, 4'b0001, LOCS, '0, 0, "R6 in-segment multi"));
    issue(mk(1, 2'd0, 2'd0, 4'b0000, '0, LOCS, '0, 0, "R9 miss default drive"));
    issue(mk(1, 2'd0, 2'd1, 4'b0010, '0, LOCS, '0, 1, "R4 beaten by upstream"));
    issue(mk(1, 2'd0, 2'd1, 4'b0000, '0, LOCS, '0, 1, "R7 upstream-only hit"));
    issue(mk(1, 2'd1, 2'd0, '0, '0, '0, 19'h5A5A5, 0, "R8 learn"));
    issue(mk(1, 2'd2, 2'd0, '0, '0, '0, 19'h13579, 0, "R8 sram write"));
    issue(mk(1, 2'd3, 2'd2, 4'b1111, 4'b1111, LOCS, 19'h7FFFF, 0, "R10 reserved op"));
    idle();
    issue(mk(1, 2'd0, 2'd2, 4'b1000, '0, LOCS, '0, 0, "R3 hit seg3"));
    issue(mk(1, 2'd0, 2'd1, 4'b1100, 4'b1000, LOCS, '0, 0, "R6 two segments"));

    // group B: middle device, no roles
    s_addr = 3'd2; s_dev = 0; s_sram = 0;
    idle();
    issue(mk(1, 2'd0, 2'd3, 4'b0010, '0, LOCS, '0, 0, "R3 middle owner"));
    issue(mk(1, 2'd0, 2'd3, 4'b0010, '0, LOCS, '0, 1, "R4 middle beaten"));
    issue(mk(1, 2'd0, 2'd0, 4'b0000, '0, LOCS, '0, 0, "R9 non-owner miss"));
    issue(mk(1, 2'd2, 2'd0, '0, '0, '0, 19'h0F0F0, 0, "R8 write non-owner"));
    issue(mk(1, 2'd3, 2'd0, 4'b0001, '0, LOCS, '0, 0, "R10 reserved middle"));

    // group C: final device without memory role
    s_addr = 3'd7; s_dev = 1; s_sram = 0;
    idle();
    issue(mk(1, 2'd0, 2'd2, 4'b0001, '0, LOCS, '0, 0, "R7 final hit"));
    issue(mk(1, 2'd0, 2'd2, 4'b0000, '0, LOCS, '0, 0, "R7 final miss"));
    issue(mk(1, 2'd0, 2'd2, 4'b0000, '0, LOCS, '0, 1, "R7 final upstream hit"));
    issue(mk(1, 2'd1, 2'd0, '0, '0, '0, 19'h11111, 0, "R8 learn non-owner"));
    idle();
    idle();
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule